// File: doc/BRIEF.md
# Pattern Rectangle Fill Engine

This engine paints an axis-aligned rectangle of a pixel frame buffer using a small stored pattern. A pattern is either a pixmap whose pixels already have the screen depth, or a one-bit bitmap whose bits turn into a foreground or background colour. Each pattern pixel is merged with the pixel already on screen through one of the sixteen classic two-operand raster functions, and the result is written back.

A command carries a pattern number, a destination origin and size, a source origin, two colours, a raster function code and a mode flag. In tiled mode the pattern is locked to the screen grid. In offset mode the given source origin lands on the destination origin. The engine reads a descriptor for the pattern from the pattern store, then visits every destination pixel in turn. It fetches the pattern word and, only when the raster function needs it, the old screen pixel, before it writes the result. Both memories answer a read on the clock edge after the request.

Top module: `patfill_engine`

## Requirements
- R1: In tiled mode (cmd_copy=0) the pattern pixel used at screen (X, Y) is the one at (X mod pw, Y mod ph), where pw and ph are the pattern width and height.
- R2: In offset mode (cmd_copy=1) the destination pixel at offset (i, j) from the rectangle origin takes pattern pixel ((sx + i) mod pw, (sy + j) mod ph).
- R3: For a bitmap (descriptor bit 16 set), pattern row r is word 1 + 2r of the pattern slot, and pixel x is bit x of that word. A set bit yields cmd_fg and a clear bit yields cmd_bg.
- R4: Pattern p occupies 17 words starting at word 17p. Word 0 holds the width in bits 7:0 and the height in bits 15:8, and bits 31:17 are zero. For a pixmap, row r starts at word 1 + 2r on a word boundary, and pixel x is byte (x mod 4) of word x/4 in that row, least significant byte first. The byte is written unchanged under the copy function.
- R5: The raster function code f gives, for each bit, the result bit f[{~s, ~d}], where s is the source bit and d is the destination bit. So 3 copies the source, 6 is the exclusive-or of source and destination, 0 clears and 15 sets.
- R6: The old destination pixel is read (fb_re) once per pixel only for codes whose result depends on it. For codes 0, 3, 12 and 15 no frame-buffer read is made.
- R7: Pixels are written once each, row by row and left to right, at frame-buffer address Y*16 + X, with one write every two cycles.
- R8: If a command is accepted in cycle 0, done is high for exactly one cycle, in cycle 3 + 2N for N pixels. cmd_ready is low from cycle 1 until the cycle after done.
- R9: A command whose width or height is zero raises done in cycle 1 and makes no pattern or frame-buffer access.
- R10: A command whose pattern number exceeds the largest valid number (3) raises done in cycle 1 and makes no memory access.
- R11: After reset cmd_ready is 1, and done, pat_re, fb_re and fb_we are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine can take a command |
| cmd_id | input | 3 | Pattern number |
| cmd_copy | input | 1 | 1 = offset mode, 0 = tiled mode |
| cmd_dx | input | 8 | Destination X origin |
| cmd_dy | input | 8 | Destination Y origin |
| cmd_w | input | 8 | Rectangle width |
| cmd_h | input | 8 | Rectangle height |
| cmd_sx | input | 8 | Source X origin (offset mode) |
| cmd_sy | input | 8 | Source Y origin (offset mode) |
| cmd_fg | input | 8 | Colour for set bitmap bits |
| cmd_bg | input | 8 | Colour for clear bitmap bits |
| cmd_rop | input | 4 | Raster function code |
| done | output | 1 | One-cycle completion pulse |
| pat_re | output | 1 | Pattern store read request |
| pat_addr | output | 7 | Pattern store word address |
| pat_rdata | input | 32 | Pattern word, valid the cycle after pat_re |
| fb_re | output | 1 | Frame buffer read request |
| fb_we | output | 1 | Frame buffer write strobe |
| fb_addr | output | 8 | Frame buffer pixel address |
| fb_wdata | output | 8 | Pixel to write |
| fb_rdata | input | 8 | Pixel read, valid the cycle after fb_re |

## Verification
The fill is run with a 3x2 pixmap, a 5x3 and a 2x2 bitmap, and an 8x8 pixmap whose rows span two words. In tiled mode the rectangle origins are offset from the pattern grid, which separates screen alignment from origin alignment. The offset-mode runs start inside the pattern and wrap in both axes, and one crosses a word boundary mid-row. Raster codes that use only the source, only the destination, and both are exercised over a frame buffer pre-loaded with distinct values, so a skipped read, a swapped operand or a wrong bit lane all change the compared image. The frame-buffer read count and the write order are checked alongside the image, and the degenerate commands are checked through their done timing and the absence of any memory access.

// File: rtl/patfill_pkg.sv
package patfill_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DESC,
        ST_DESCW,
        ST_FETCH,
        ST_WRITE
    } fill_state_t;

    // Pattern descriptor word: reserved bits must be zero
    typedef struct packed {
        logic [14:0] rsvd;
        logic        is_bitmap;
        logic [7:0]  height;
        logic [7:0]  width;
    } pat_desc_t;

    localparam logic [3:0] ROP_CLEAR = 4'h0;
    localparam logic [3:0] ROP_COPY  = 4'h3;
    localparam logic [3:0] ROP_XOR   = 4'h6;
    localparam logic [3:0] ROP_NSRC  = 4'hC;
    localparam logic [3:0] ROP_SET   = 4'hF;

    // A function needs the destination when its truth table differs along d
    function automatic logic rop_needs_dst(input logic [3:0] f);
        return (f[0] != f[1]) || (f[2] != f[3]);
    endfunction

endpackage

// File: rtl/patfill_rop.sv
module patfill_rop #(
    parameter int PIX_W = 8
) (
    input  logic [3:0]       code,
    input  logic [PIX_W-1:0] src,
    input  logic [PIX_W-1:0] dst,
    output logic [PIX_W-1:0] res
);
    for (genvar b = 0; b < PIX_W; b++) begin : g_bit
        logic [1:0] sel;
        assign sel    = {~src[b], ~dst[b]};
        assign res[b] = code[sel];
    end
endmodule

// File: rtl/patfill_expand.sv
module patfill_expand
    import patfill_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic [WORD_W-1:0] word,
    input  logic [4:0]        sel,
    input  logic              is_bitmap,
    input  logic [PIX_W-1:0]  fg,
    input  logic [PIX_W-1:0]  bg,
    output logic [PIX_W-1:0]  pix
);
    localparam int PPW    = WORD_W / PIX_W;
    localparam int LANE_W = (PPW > 1) ? $clog2(PPW) : 1;

    logic [PIX_W-1:0] lane_pix;
    logic             mono_bit;

    if (PPW > 1) begin : g_multi
        logic [LANE_W-1:0] lane;
        assign lane     = sel[LANE_W-1:0];
        assign lane_pix = word[lane*PIX_W +: PIX_W];
    end else begin : g_single
        assign lane_pix = word[PIX_W-1:0];
    end

    assign mono_bit = word[sel];
    assign pix      = is_bitmap ? (mono_bit ? fg : bg) : lane_pix;
endmodule

// File: rtl/patfill_walker.sv
module patfill_walker #(
    parameter int COORD_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               step,
    input  logic               active,
    input  logic [COORD_W-1:0] dx0,
    input  logic [COORD_W-1:0] dy0,
    input  logic [COORD_W-1:0] w,
    input  logic [COORD_W-1:0] h,
    input  logic [COORD_W-1:0] pw,
    input  logic [COORD_W-1:0] ph,
    input  logic [COORD_W-1:0] px0,
    input  logic [COORD_W-1:0] py0,
    output logic [COORD_W-1:0] cur_x,
    output logic [COORD_W-1:0] cur_y,
    output logic [COORD_W-1:0] pat_x,
    output logic [COORD_W-1:0] pat_y,
    output logic               last
);
    logic [COORD_W-1:0] ox_q, oy_q, w_q, h_q, pw_q, ph_q;
    logic [COORD_W-1:0] cx_q, cy_q, px_q, py_q, px0_q;
    logic               row_end;

    assign row_end = (cx_q == w_q - 1'b1);
    assign last    = row_end && (cy_q == h_q - 1'b1);
    assign cur_x   = ox_q + cx_q;
    assign cur_y   = oy_q + cy_q;
    assign pat_x   = px_q;
    assign pat_y   = py_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ox_q  <= '0;
            oy_q  <= '0;
            w_q   <= '0;
            h_q   <= '0;
            pw_q  <= '0;
            ph_q  <= '0;
            cx_q  <= '0;
            cy_q  <= '0;
            px_q  <= '0;
            py_q  <= '0;
            px0_q <= '0;
        end else if (load) begin
            ox_q  <= dx0;
            oy_q  <= dy0;
            w_q   <= w;
            h_q   <= h;
            pw_q  <= pw;
            ph_q  <= ph;
            cx_q  <= '0;
            cy_q  <= '0;
            px_q  <= px0;
            py_q  <= py0;
            px0_q <= px0;
        end else if (step) begin
            if (row_end) begin
                cx_q <= '0;
                cy_q <= cy_q + 1'b1;
                px_q <= px0_q;
                py_q <= (py_q == ph_q - 1'b1) ? '0 : py_q + 1'b1;
            end else begin
                cx_q <= cx_q + 1'b1;
                px_q <= (px_q == pw_q - 1'b1) ? '0 : px_q + 1'b1;
            end
        end
    end

    // R1
    pat_range_chk: assert property (@(posedge clk) disable iff (rst)
        active |-> (px_q < pw_q) && (py_q < ph_q));
endmodule

// File: rtl/patfill_engine.sv
module patfill_engine
    import patfill_pkg::*;
#(
    parameter int PIX_W     = 8,
    parameter int COORD_W   = 8,
    parameter int ID_W      = 3,
    parameter int MAX_ID    = 3,
    parameter int PAT_MAX   = 8,
    parameter int FB_STRIDE = 16,
    parameter int FB_ROWS   = 16,
    localparam int PPW      = WORD_W / PIX_W,
    localparam int WPR      = (PAT_MAX + PPW - 1) / PPW,
    localparam int SLOT     = 1 + PAT_MAX * WPR,
    localparam int PAT_AW   = $clog2((MAX_ID + 1) * SLOT),
    localparam int FB_AW    = $clog2(FB_STRIDE * FB_ROWS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic [ID_W-1:0]    cmd_id,
    input  logic               cmd_copy,
    input  logic [COORD_W-1:0] cmd_dx,
    input  logic [COORD_W-1:0] cmd_dy,
    input  logic [COORD_W-1:0] cmd_w,
    input  logic [COORD_W-1:0] cmd_h,
    input  logic [COORD_W-1:0] cmd_sx,
    input  logic [COORD_W-1:0] cmd_sy,
    input  logic [PIX_W-1:0]   cmd_fg,
    input  logic [PIX_W-1:0]   cmd_bg,
    input  logic [3:0]         cmd_rop,
    output logic               done,
    output logic               pat_re,
    output logic [PAT_AW-1:0]  pat_addr,
    input  logic [WORD_W-1:0]  pat_rdata,
    output logic               fb_re,
    output logic               fb_we,
    output logic [FB_AW-1:0]   fb_addr,
    output logic [PIX_W-1:0]   fb_wdata,
    input  logic [PIX_W-1:0]   fb_rdata
);
    localparam int LANE_SH = (PPW > 1) ? $clog2(PPW) : 0;

    fill_state_t         state_q;
    logic                done_q;
    logic [ID_W-1:0]     id_q;
    logic                copy_q;
    logic                bmp_q;
    logic                need_dst_q;
    logic [COORD_W-1:0]  dx_q, dy_q, w_q, h_q, sx_q, sy_q;
    logic [PIX_W-1:0]    fg_q, bg_q;
    logic [3:0]          rop_q;

    pat_desc_t           desc;
    logic                desc_bad;
    logic [COORD_W-1:0]  pw_in, ph_in, pw_safe, ph_safe, px0, py0;
    logic                accept, trivial;

    logic [COORD_W-1:0]  cur_x, cur_y, pat_x, pat_y;
    logic                last;
    logic                walk_load, walk_step, walk_active;

    logic [PAT_AW-1:0]   base_addr, row_off, lane_word, fetch_addr;
    logic [PIX_W-1:0]    src_pix, rop_res;

    // Command acceptance
    assign cmd_ready = (state_q == ST_IDLE) && !done_q;
    assign accept    = cmd_valid && cmd_ready;
    assign trivial   = (cmd_w == '0) || (cmd_h == '0) || (cmd_id > ID_W'(MAX_ID));
    assign done      = done_q;

    // Descriptor decode
    assign desc     = pat_desc_t'(pat_rdata);
    assign pw_in    = COORD_W'(desc.width);
    assign ph_in    = COORD_W'(desc.height);
    assign desc_bad = (pw_in == '0) || (ph_in == '0) ||
                      (pw_in > COORD_W'(PAT_MAX)) || (ph_in > COORD_W'(PAT_MAX)) ||
                      (|desc.rsvd);
    assign pw_safe  = (pw_in == '0) ? COORD_W'(1) : pw_in;
    assign ph_safe  = (ph_in == '0) ? COORD_W'(1) : ph_in;
    assign px0      = (copy_q ? sx_q : dx_q) % pw_safe;
    assign py0      = (copy_q ? sy_q : dy_q) % ph_safe;

    assign walk_load   = (state_q == ST_DESCW) && !desc_bad;
    assign walk_step   = (state_q == ST_WRITE);
    assign walk_active = (state_q == ST_FETCH) || (state_q == ST_WRITE);

    patfill_walker #(.COORD_W(COORD_W)) u_walk (
        .clk    (clk),
        .rst    (rst),
        .load   (walk_load),
        .step   (walk_step),
        .active (walk_active),
        .dx0    (dx_q),
        .dy0    (dy_q),
        .w      (w_q),
        .h      (h_q),
        .pw     (pw_in),
        .ph     (ph_in),
        .px0    (px0),
        .py0    (py0),
        .cur_x  (cur_x),
        .cur_y  (cur_y),
        .pat_x  (pat_x),
        .pat_y  (pat_y),
        .last   (last)
    );

    // Pattern word address
    assign base_addr  = PAT_AW'(id_q) * PAT_AW'(SLOT);
    assign row_off    = PAT_AW'(pat_y) * PAT_AW'(WPR);
    assign lane_word  = bmp_q ? '0 : PAT_AW'(pat_x >> LANE_SH);
    assign fetch_addr = base_addr + PAT_AW'(1) + row_off + lane_word;

    assign pat_re   = (state_q == ST_DESC) || (state_q == ST_FETCH);
    assign pat_addr = (state_q == ST_DESC) ? base_addr : fetch_addr;

    // Frame buffer side
    assign fb_re   = (state_q == ST_FETCH) && need_dst_q;
    assign fb_we   = (state_q == ST_WRITE);
    assign fb_addr = FB_AW'(cur_y) * FB_AW'(FB_STRIDE) + FB_AW'(cur_x);

    patfill_expand #(.PIX_W(PIX_W)) u_expand (
        .word      (pat_rdata),
        .sel       (pat_x[4:0]),
        .is_bitmap (bmp_q),
        .fg        (fg_q),
        .bg        (bg_q),
        .pix       (src_pix)
    );

    patfill_rop #(.PIX_W(PIX_W)) u_rop (
        .code (rop_q),
        .src  (src_pix),
        .dst  (fb_rdata),
        .res  (rop_res)
    );

    assign fb_wdata = rop_res;

    // Sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            done_q     <= 1'b0;
            id_q       <= '0;
            copy_q     <= 1'b0;
            bmp_q      <= 1'b0;
            need_dst_q <= 1'b0;
            dx_q       <= '0;
            dy_q       <= '0;
            w_q        <= '0;
            h_q        <= '0;
            sx_q       <= '0;
            sy_q       <= '0;
            fg_q       <= '0;
            bg_q       <= '0;
            rop_q      <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        id_q       <= cmd_id;
                        copy_q     <= cmd_copy;
                        dx_q       <= cmd_dx;
                        dy_q       <= cmd_dy;
                        w_q        <= cmd_w;
                        h_q        <= cmd_h;
                        sx_q       <= cmd_sx;
                        sy_q       <= cmd_sy;
                        fg_q       <= cmd_fg;
                        bg_q       <= cmd_bg;
                        rop_q      <= cmd_rop;
                        need_dst_q <= rop_needs_dst(cmd_rop);
                        if (trivial) done_q  <= 1'b1;
                        else         state_q <= ST_DESC;
                    end
                end
                ST_DESC:  state_q <= ST_DESCW;
                ST_DESCW: begin
                    bmp_q <= desc.is_bitmap;
                    if (desc_bad) begin
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        state_q <= ST_FETCH;
                    end
                end
                ST_FETCH: state_q <= ST_WRITE;
                ST_WRITE: begin
                    if (last) begin
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        state_q <= ST_FETCH;
                    end
                end
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    write_after_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        fb_we |-> $past(pat_re));

    // R6
    dst_read_used_chk: assert property (@(posedge clk) disable iff (rst)
        (fb_we && rop_needs_dst(rop_q)) |-> $past(fb_re));

    // R6
    dst_read_skipped_chk: assert property (@(posedge clk) disable iff (rst)
        (fb_we && !rop_needs_dst(rop_q)) |-> !$past(fb_re));

    // R5
    xor_merge_chk: assert property (@(posedge clk) disable iff (rst)
        (fb_we && rop_q == ROP_XOR) |-> fb_wdata == (src_pix ^ fb_rdata));

    // R9
    empty_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && (cmd_w == '0 || cmd_h == '0)) |=> done && !pat_re && !fb_re && !fb_we);

    // R10
    bad_id_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && cmd_id > ID_W'(MAX_ID)) |=> done && !pat_re && !fb_re && !fb_we);
endmodule

// File: tb/tb_patfill_engine.sv
module tb_patfill_engine;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;

    typedef struct packed {
        logic [2:0] id;
        logic       cp;
        logic [7:0] dx, dy, w, h, sx, sy;
        logic [7:0] fg, bg;
        logic [3:0] rop;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{3'd0, 1'b0, 8'd1,  8'd1,  8'd5,  8'd3, 8'd0, 8'd0, 8'h00, 8'h00, 4'h3},
        '{3'd1, 1'b0, 8'd2,  8'd5,  8'd7,  8'd2, 8'd0, 8'd0, 8'hAA, 8'h55, 4'h3},
        '{3'd0, 1'b1, 8'd8,  8'd0,  8'd4,  8'd3, 8'd2, 8'd1, 8'h00, 8'h00, 4'h3},
        '{3'd1, 1'b1, 8'd2,  8'd5,  8'd4,  8'd2, 8'd4, 8'd2, 8'hF0, 8'h0F, 4'h6},
        '{3'd2, 1'b0, 8'd0,  8'd8,  8'd10, 8'd2, 8'd0, 8'd0, 8'h00, 8'h00, 4'h1},
        '{3'd0, 1'b0, 8'd1,  8'd1,  8'd2,  8'd1, 8'd0, 8'd0, 8'h00, 8'h00, 4'hA},
        '{3'd2, 1'b1, 8'd3,  8'd12, 8'd3,  8'd2, 8'd6, 8'd7, 8'h00, 8'h00, 4'hC},
        '{3'd3, 1'b0, 8'd12, 8'd12, 8'd2,  8'd2, 8'd0, 8'd0, 8'h11, 8'h22, 4'h0}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid, cmd_ready, cmd_copy, done;
    logic [2:0]  cmd_id;
    logic [7:0]  cmd_dx, cmd_dy, cmd_w, cmd_h, cmd_sx, cmd_sy, cmd_fg, cmd_bg;
    logic [3:0]  cmd_rop;
    logic        pat_re, fb_re, fb_we;
    logic [6:0]  pat_addr;
    logic [31:0] pat_rdata;
    logic [7:0]  fb_addr, fb_wdata, fb_rdata;

    logic [31:0] pat_mem [68];
    logic [7:0]  fb_mem  [256];
    logic [7:0]  ref_fb  [256];

    int checks = 0, fails = 0, cyc = 0;
    int n_wr, n_rd, n_pat, order_err;
    int ord_dx, ord_dy, ord_w, ord_cx, ord_cy;

    always #(CLK_PERIOD/2) clk = ~clk;

    patfill_engine dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_id(cmd_id), .cmd_copy(cmd_copy), .cmd_dx(cmd_dx), .cmd_dy(cmd_dy),
        .cmd_w(cmd_w), .cmd_h(cmd_h), .cmd_sx(cmd_sx), .cmd_sy(cmd_sy),
        .cmd_fg(cmd_fg), .cmd_bg(cmd_bg), .cmd_rop(cmd_rop), .done(done),
        .pat_re(pat_re), .pat_addr(pat_addr), .pat_rdata(pat_rdata),
        .fb_re(fb_re), .fb_we(fb_we), .fb_addr(fb_addr), .fb_wdata(fb_wdata),
        .fb_rdata(fb_rdata)
    );

    // Memories with one-cycle read latency
    always @(posedge clk) begin
        if (pat_re) pat_rdata <= pat_mem[pat_addr];
        if (fb_re)  fb_rdata  <= fb_mem[fb_addr];
        if (fb_we)  fb_mem[fb_addr] <= fb_wdata;
    end

    // Pattern library kept by the bench
    function automatic int pw_of(input int id);
        case (id) 0: return 3; 1: return 5; 2: return 8; default: return 2; endcase
    endfunction
    function automatic int ph_of(input int id);
        case (id) 0: return 2; 1: return 3; 2: return 8; default: return 2; endcase
    endfunction
    function automatic bit is_bmp(input int id);
        return (id == 1) || (id == 3);
    endfunction
    function automatic logic [7:0] pix_val(input int id, input int x, input int y);
        if (id == 0) return 8'(16 * y + x + 1);
        return 8'(x * 29 + y * 13 + 7);
    endfunction
    function automatic bit bit_val(input int id, input int x, input int y);
        if (id == 1) return ((x * 3 + y) % 4) == 0;
        return ((x ^ y) & 1) == 1;
    endfunction

    function automatic logic [7:0] ref_rop(input logic [3:0] f, input logic [7:0] s, input logic [7:0] d);
        case (f)
            4'h0: return 8'h00;     4'h1: return s & d;
            4'h2: return s & ~d;    4'h3: return s;
            4'h4: return ~s & d;    4'h5: return d;
            4'h6: return s ^ d;     4'h7: return s | d;
            4'h8: return ~(s | d);  4'h9: return ~(s ^ d);
            4'hA: return ~d;        4'hB: return s | ~d;
            4'hC: return ~s;        4'hD: return ~s | d;
            4'hE: return ~(s & d);  default: return 8'hFF;
        endcase
    endfunction
    function automatic bit ref_uses_dst(input logic [3:0] f);
        return !(f == 4'h0 || f == 4'h3 || f == 4'hC || f == 4'hF);
    endfunction

    function automatic string tag_of(input int i);
        case (i)
            0: return "R1 R4 tiled pixmap";
            1: return "R3 tiled bitmap";
            2: return "R2 offset pixmap";
            3: return "R5 R2 offset bitmap xor";
            4: return "R4 wide pixmap and";
            5: return "R6 invert dst-only";
            6: return "R6 R2 copy-inverted across word";
            default: return "R5 clear bitmap";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Observe strobes mid-cycle; track write order (R7)
    always @(negedge clk) begin
        if (fb_we) begin
            n_wr++;
            if (int'(fb_addr) != (ord_dy + ord_cy) * 16 + ord_dx + ord_cx) order_err++;
            if (ord_cx == ord_w - 1) begin ord_cx = 0; ord_cy++; end
            else ord_cx++;
        end
        if (fb_re)  n_rd++;
        if (pat_re) n_pat++;
    end

    task automatic run_cmd(input vec_t v, input string tag);
        int n, exp_done, done_at, done_cnt, mism, c;
        bit ok_cmd;
        ok_cmd   = (v.w != 0) && (v.h != 0) && (v.id <= 3);
        n        = ok_cmd ? int'(v.w) * int'(v.h) : 0;
        exp_done = ok_cmd ? 3 + 2 * n : 1;
        if (ok_cmd) begin
            for (int j = 0; j < int'(v.h); j++) begin
                for (int i = 0; i < int'(v.w); i++) begin
                    int xx, yy, px, py;
                    logic [7:0] s;
                    xx = int'(v.dx) + i;
                    yy = int'(v.dy) + j;
                    px = v.cp ? (int'(v.sx) + i) % pw_of(v.id) : xx % pw_of(v.id);
                    py = v.cp ? (int'(v.sy) + j) % ph_of(v.id) : yy % ph_of(v.id);
                    if (is_bmp(v.id)) s = bit_val(v.id, px, py) ? v.fg : v.bg;
                    else              s = pix_val(v.id, px, py);
                    ref_fb[yy * 16 + xx] = ref_rop(v.rop, s, ref_fb[yy * 16 + xx]);
                end
            end
        end
        ord_dx = v.dx; ord_dy = v.dy; ord_w = v.w; ord_cx = 0; ord_cy = 0;
        order_err = 0; n_wr = 0; n_rd = 0; n_pat = 0;

        @(negedge clk);
        check(cmd_ready == 1'b1, {"R8 ready before ", tag}, cmd_ready, 1);
        cmd_valid = 1'b1;
        cmd_id = v.id; cmd_copy = v.cp; cmd_dx = v.dx; cmd_dy = v.dy;
        cmd_w = v.w; cmd_h = v.h; cmd_sx = v.sx; cmd_sy = v.sy;
        cmd_fg = v.fg; cmd_bg = v.bg; cmd_rop = v.rop;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(cmd_ready == 1'b0, {"R8 ready low ", tag}, cmd_ready, 0);
        done_at = -1; done_cnt = 0;
        for (c = 1; c <= exp_done + 4; c++) begin
            if (done) begin
                done_cnt++;
                if (done_at < 0) done_at = c;
            end
            @(negedge clk);
        end
        mism = 0;
        for (int k = 0; k < 256; k++) if (fb_mem[k] !== ref_fb[k]) mism++;
        check(done_at == exp_done, {"R8 done cycle ", tag}, done_at, exp_done);
        check(done_cnt == 1, {"R8 done pulse ", tag}, done_cnt, 1);
        check(n_wr == n, {"R7 write count ", tag}, n_wr, n);
        check(order_err == 0, {"R7 write order ", tag}, order_err, 0);
        check(n_rd == (ref_uses_dst(v.rop) ? n : 0), {"R6 dst reads ", tag}, n_rd,
              ref_uses_dst(v.rop) ? n : 0);
        check(n_pat == (ok_cmd ? n + 1 : 0), {"R9 R10 pattern reads ", tag}, n_pat,
              ok_cmd ? n + 1 : 0);
        check(mism == 0, {"R1 R2 R3 R4 R5 image ", tag}, mism, 0);
    endtask

    initial begin
        cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                fails++;
                checks++;
                $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        vec_t zv;
        rst = 1'b1; cmd_valid = 1'b0;
        cmd_id = '0; cmd_copy = 1'b0; cmd_dx = '0; cmd_dy = '0; cmd_w = '0; cmd_h = '0;
        cmd_sx = '0; cmd_sy = '0; cmd_fg = '0; cmd_bg = '0; cmd_rop = '0;
        n_wr = 0; n_rd = 0; n_pat = 0; order_err = 0;
        ord_dx = 0; ord_dy = 0; ord_w = 1; ord_cx = 0; ord_cy = 0;

        // Build pattern store from the layout in R3 and R4
        for (int a = 0; a < 68; a++) pat_mem[a] = '0;
        for (int id = 0; id < 4; id++) begin
            int base;
            base = id * 17;
            pat_mem[base] = {15'd0, is_bmp(id), 8'(ph_of(id)), 8'(pw_of(id))};
            for (int y = 0; y < ph_of(id); y++) begin
                for (int x = 0; x < pw_of(id); x++) begin
                    if (is_bmp(id)) pat_mem[base + 1 + 2 * y][x] = bit_val(id, x, y);
                    else pat_mem[base + 1 + 2 * y + x / 4][8 * (x % 4) +: 8] = pix_val(id, x, y);
                end
            end
        end
        for (int k = 0; k < 256; k++) begin
            fb_mem[k] = 8'(k * 7 + 3);
            ref_fb[k] = 8'(k * 7 + 3);
        end

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        check(cmd_ready == 1'b1, "R11 ready after reset", cmd_ready, 1);
        check(done == 1'b0, "R11 done after reset", done, 0);
        check({pat_re, fb_re, fb_we} == 3'b000, "R11 strobes after reset",
              {pat_re, fb_re, fb_we}, 0);

        for (int i = 0; i < NV; i++) run_cmd(VECS[i], tag_of(i));

        // R9 zero width and zero height
        zv = VECS[0]; zv.w = 8'd0;
        run_cmd(zv, "R9 zero width");
        zv = VECS[1]; zv.h = 8'd0;
        run_cmd(zv, "R9 zero height");
        // R10 pattern number out of range
        zv = VECS[0]; zv.id = 3'd5;
        run_cmd(zv, "R10 bad id");
        // Work still correct after the degenerate commands
        run_cmd(VECS[3], "R5 R8 xor after degenerate");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule